// File: doc/BRIEF.md
# Route-Aware Lane Change Judge

This block decides, for one road cell of a cellular traffic model, whether the car in that cell should move into the lane to its left or to its right. A left move may only be chosen on odd time steps and a right move only on even time steps, so two cars can never be sent into the same cell from opposite sides.

For the side allowed by the step parity, the block compares link identifiers against the car's route. The target cell's link, the car's current and next route links, and the cell's precomputed next-left and next-right link identifiers are checked in a fixed order of priority. Only when none of the route comparisons decides does the block use the gap-based wish supplied by an upstream stage. A flag is raised only when the cell holds a car and the upstream safety check allows the move.

The block is one register stage. A valid strobe travels with the data and the flags appear one clock after the inputs are sampled.

Top module: `lane_shift_judge`

## Requirements
- R1: go_left can be 1 only for an input sampled with step_odd = 1 (odd step).
- R2: go_right can be 1 only for an input sampled with step_odd = 0 (even step).
- R3: Highest priority: if the side's target link equals route_next_link, the move is wanted, whatever the gap-based wish.
- R4: Second priority: if the target link differs from both route_next_link and route_cur_link, the move is not wanted, whatever the gap-based wish.
- R5: Third priority: if the target link equals route_cur_link and the cell's next link on that side (cell_next_left for left, cell_next_right for right) equals route_next_link, the move is wanted.
- R6: Otherwise the side's gap-based wish (gap_want_left / gap_want_right) decides.
- R7: A flag is 1 only if car_present = 1 and that side's gap_safe input = 1 for the same sampled input.
- R8: A link identifier of 0 means no link and never equals any other value, including another 0.
- R9: valid_out, go_left and go_right are registered: they reflect the inputs sampled on the previous rising clock edge, and valid_out equals the previous valid_in.
- R10: While rst_n = 0 (synchronous, active low), valid_out, go_left and go_right are 0 after the clock edge.
- R11: When valid_in = 0 is sampled, both flags are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | Input record is valid |
| step_odd | input | 1 | 1 on odd time steps, 0 on even |
| car_present | input | 1 | Cell holds a car |
| route_cur_link | input | LINK_W | Link the car's route is currently on |
| route_next_link | input | LINK_W | Next leg of the car's route |
| left_tgt_link | input | LINK_W | Link of the adjacent left target cell |
| right_tgt_link | input | LINK_W | Link of the adjacent right target cell |
| cell_next_left | input | LINK_W | Link reached by the next left turn from this cell |
| cell_next_right | input | LINK_W | Link reached by the next right turn from this cell |
| gap_want_left | input | 1 | Gap-based wish to move left |
| gap_want_right | input | 1 | Gap-based wish to move right |
| gap_safe_left | input | 1 | Left move is permitted by gaps |
| gap_safe_right | input | 1 | Right move is permitted by gaps |
| valid_out | output | 1 | Output flags are valid |
| go_left | output | 1 | Change into the left lane |
| go_right | output | 1 | Change into the right lane |

## Verification
The assertions watch every cycle for parity gating of each side, for flags never being raised without a car and a safe gap, for the two flags never being set together, for the route-hit priority forcing a flag, and for the valid strobe following its input by one cycle. Whether the cascade resolves the second, third and fourth priorities in the right order, and that identifier zero never matches, can only be shown by the bench's directed and random scenarios compared against its reference function.

// File: rtl/lsj_pkg.sv
package lsj_pkg;
   typedef enum logic [2:0] {
      RULE_IDLE  = 3'd0,
      RULE_HIT   = 3'd1,
      RULE_WRONG = 3'd2,
      RULE_PREP  = 3'd3,
      RULE_GAP   = 3'd4
   } rule_e;

   localparam int NUM_SIDES = 2;
   localparam int SIDE_LEFT = 0;
   localparam int SIDE_RIGHT = 1;
endpackage

// File: rtl/lsj_side_eval.sv
module lsj_side_eval
   import lsj_pkg::*;
#(
   parameter int LINK_W = 16
) (
   input  logic              side_active,
   input  logic              car_present,
   input  logic [LINK_W-1:0] tgt_link,
   input  logic [LINK_W-1:0] cur_link,
   input  logic [LINK_W-1:0] next_link,
   input  logic [LINK_W-1:0] turn_link,
   input  logic              gap_want,
   input  logic              gap_safe,
   output rule_e             rule_used,
   output logic              flag
);
   localparam logic [LINK_W-1:0] NO_LINK = '0;

   logic tgt_is_next, tgt_is_cur, turn_is_next, wanted;

   // zero is "no link" and never equals anything
   assign tgt_is_next  = (tgt_link != NO_LINK) && (tgt_link == next_link);
   assign tgt_is_cur   = (tgt_link != NO_LINK) && (tgt_link == cur_link);
   assign turn_is_next = (turn_link != NO_LINK) && (turn_link == next_link);

   always_comb begin
      rule_used = RULE_IDLE;
      wanted    = 1'b0;
      if (side_active && car_present) begin
         if (tgt_is_next) begin
            rule_used = RULE_HIT;
            wanted    = 1'b1;
         end else if (!tgt_is_cur) begin
            rule_used = RULE_WRONG;
            wanted    = 1'b0;
         end else if (turn_is_next) begin
            rule_used = RULE_PREP;
            wanted    = 1'b1;
         end else begin
            rule_used = RULE_GAP;
            wanted    = gap_want;
         end
      end
   end

   assign flag = wanted && gap_safe;
endmodule

// File: rtl/lsj_out_reg.sv
module lsj_out_reg #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vld_d,
   input  logic [W-1:0] dat_d,
   output logic         vld_q,
   output logic [W-1:0] dat_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         dat_q <= '0;
      end else begin
         vld_q <= vld_d;
         dat_q <= vld_d ? dat_d : '0;
      end
   end

   a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      vld_d |=> vld_q);
   a_r11_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_d |=> (dat_q == '0));
endmodule

// File: rtl/lane_shift_judge.sv
module lane_shift_judge
   import lsj_pkg::*;
#(
   parameter int LINK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_in,
   input  logic              step_odd,
   input  logic              car_present,
   input  logic [LINK_W-1:0] route_cur_link,
   input  logic [LINK_W-1:0] route_next_link,
   input  logic [LINK_W-1:0] left_tgt_link,
   input  logic [LINK_W-1:0] right_tgt_link,
   input  logic [LINK_W-1:0] cell_next_left,
   input  logic [LINK_W-1:0] cell_next_right,
   input  logic              gap_want_left,
   input  logic              gap_want_right,
   input  logic              gap_safe_left,
   input  logic              gap_safe_right,
   output logic              valid_out,
   output logic              go_left,
   output logic              go_right
);
   initial begin
      if (LINK_W < 2) $error("LINK_W must be at least 2");
   end

   logic [LINK_W-1:0] tgt_v  [NUM_SIDES];
   logic [LINK_W-1:0] turn_v [NUM_SIDES];
   logic [NUM_SIDES-1:0] want_v, safe_v, act_v, flag_d, flag_q;
   rule_e rule_v [NUM_SIDES];

   assign tgt_v[SIDE_LEFT]   = left_tgt_link;
   assign tgt_v[SIDE_RIGHT]  = right_tgt_link;
   assign turn_v[SIDE_LEFT]  = cell_next_left;
   assign turn_v[SIDE_RIGHT] = cell_next_right;
   assign want_v = {gap_want_right, gap_want_left};
   assign safe_v = {gap_safe_right, gap_safe_left};
   // odd steps open the left side, even steps the right side
   assign act_v  = {~step_odd, step_odd};

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      lsj_side_eval #(.LINK_W(LINK_W)) u_eval (
         .side_active (act_v[s]),
         .car_present (car_present),
         .tgt_link    (tgt_v[s]),
         .cur_link    (route_cur_link),
         .next_link   (route_next_link),
         .turn_link   (turn_v[s]),
         .gap_want    (want_v[s]),
         .gap_safe    (safe_v[s]),
         .rule_used   (rule_v[s]),
         .flag        (flag_d[s])
      );
   end

   lsj_out_reg #(.W(NUM_SIDES)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_d (valid_in),
      .dat_d (flag_d),
      .vld_q (valid_out),
      .dat_q (flag_q)
   );

   assign go_left  = flag_q[SIDE_LEFT];
   assign go_right = flag_q[SIDE_RIGHT];

   a_r1_left_on_odd: assert property (@(posedge clk) disable iff (!rst_n)
      go_left |-> $past(step_odd));
   a_r2_right_on_even: assert property (@(posedge clk) disable iff (!rst_n)
      go_right |-> !$past(step_odd));
   a_r7_left_needs_car_safe: assert property (@(posedge clk) disable iff (!rst_n)
      go_left |-> ($past(car_present) && $past(gap_safe_left)));
   a_r7_right_needs_car_safe: assert property (@(posedge clk) disable iff (!rst_n)
      go_right |-> ($past(car_present) && $past(gap_safe_right)));
   a_r9_flags_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (go_left || go_right) |-> valid_out);
   a_r1_one_side_only: assert property (@(posedge clk) disable iff (!rst_n)
      !(go_left && go_right));
   a_r3_route_hit_left: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && step_odd && car_present && gap_safe_left &&
       left_tgt_link != '0 && left_tgt_link == route_next_link) |=> go_left);
endmodule

// File: tb/lane_shift_judge_test.sv
module lane_shift_judge_test;
   localparam int LW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic valid_in = 0, step_odd = 0, car_present = 0;
   logic [LW-1:0] route_cur_link = '0, route_next_link = '0;
   logic [LW-1:0] left_tgt_link = '0, right_tgt_link = '0;
   logic [LW-1:0] cell_next_left = '0, cell_next_right = '0;
   logic gap_want_left = 0, gap_want_right = 0, gap_safe_left = 0, gap_safe_right = 0;
   logic valid_out, go_left, go_right;

   int n_vec = 0, n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   lane_shift_judge #(.LINK_W(LW)) uut (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .step_odd(step_odd),
      .car_present(car_present), .route_cur_link(route_cur_link),
      .route_next_link(route_next_link), .left_tgt_link(left_tgt_link),
      .right_tgt_link(right_tgt_link), .cell_next_left(cell_next_left),
      .cell_next_right(cell_next_right), .gap_want_left(gap_want_left),
      .gap_want_right(gap_want_right), .gap_safe_left(gap_safe_left),
      .gap_safe_right(gap_safe_right), .valid_out(valid_out),
      .go_left(go_left), .go_right(go_right));

   function automatic bit eq_nz(logic [LW-1:0] a, logic [LW-1:0] b);
      return (a != 0) && (a == b);
   endfunction

   function automatic bit ref_side(bit active, bit car, logic [LW-1:0] tgt,
         logic [LW-1:0] cur, logic [LW-1:0] nxt, logic [LW-1:0] turn,
         bit want, bit safe);
      bit w;
      if (!active || !car) return 0;
      if (eq_nz(tgt, nxt)) w = 1;
      else if (!eq_nz(tgt, cur)) w = 0;
      else if (eq_nz(turn, nxt)) w = 1;
      else w = want;
      return w && safe;
   endfunction

   task automatic check(string tag, bit act, bit exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b", tag, act, exp);
      end
   endtask

   // drive at negedge, check one cycle later at the following negedge
   task automatic apply(string tag, bit v, bit odd, bit car,
         logic [LW-1:0] cur, logic [LW-1:0] nxt, logic [LW-1:0] lt,
         logic [LW-1:0] rt, logic [LW-1:0] nl, logic [LW-1:0] nr,
         bit wl, bit wr, bit sl, bit sr);
      bit el, er;
      valid_in = v; step_odd = odd; car_present = car;
      route_cur_link = cur; route_next_link = nxt;
      left_tgt_link = lt; right_tgt_link = rt;
      cell_next_left = nl; cell_next_right = nr;
      gap_want_left = wl; gap_want_right = wr;
      gap_safe_left = sl; gap_safe_right = sr;
      el = v && ref_side(odd, car, lt, cur, nxt, nl, wl, sl);
      er = v && ref_side(!odd, car, rt, cur, nxt, nr, wr, sr);
      @(negedge clk);
      check({tag, " R9 valid"}, valid_out, v);
      check({tag, " left"}, go_left, el);
      check({tag, " right"}, go_right, er);
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      valid_in = 1; step_odd = 1; car_present = 1;
      left_tgt_link = 5; route_next_link = 5; gap_safe_left = 1;
      repeat (3) @(negedge clk);
      // R10 reset holds outputs low even with valid input
      check("R10 valid_out", valid_out, 0);
      check("R10 go_left", go_left, 0);
      check("R10 go_right", go_right, 0);
      rst_n = 1;
      valid_in = 0;
      @(negedge clk);
      // R3 route hit overrides gap wish (left, odd)
      apply("R3 left hit", 1, 1, 1, 7, 5, 5, 0, 0, 0, 0, 0, 1, 1);
      // R1 same situation on even step: left blocked
      apply("R1 even blocks left", 1, 0, 1, 7, 5, 5, 9, 0, 0, 1, 0, 1, 1);
      // R2 right hit on even
      apply("R2 right hit even", 1, 0, 1, 7, 5, 0, 5, 0, 0, 0, 0, 1, 1);
      apply("R2 odd blocks right", 1, 1, 1, 7, 5, 9, 5, 0, 0, 0, 1, 1, 1);
      // R4 wrong turn overrides gap wish
      apply("R4 wrong link", 1, 1, 1, 7, 5, 3, 0, 5, 0, 1, 1, 1, 1);
      // R5 prepare for turn
      apply("R5 prep left", 1, 1, 1, 7, 5, 7, 0, 5, 0, 0, 0, 1, 1);
      apply("R5 prep right", 1, 0, 1, 7, 5, 0, 7, 0, 5, 0, 0, 1, 1);
      // R6 gap wish decides
      apply("R6 gap yes", 1, 1, 1, 7, 5, 7, 0, 2, 0, 1, 0, 1, 1);
      apply("R6 gap no", 1, 1, 1, 7, 5, 7, 0, 2, 0, 0, 0, 1, 1);
      // R7 no car / unsafe
      apply("R7 no car", 1, 1, 0, 7, 5, 5, 0, 0, 0, 1, 1, 1, 1);
      apply("R7 unsafe", 1, 1, 1, 7, 5, 5, 0, 0, 0, 1, 1, 0, 1);
      // R8 zero never matches: tgt=0 and next=0 -> wrong-turn, not wanted
      apply("R8 zero tgt", 1, 1, 1, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1);
      apply("R8 zero turn", 1, 1, 1, 7, 0, 7, 0, 0, 0, 0, 0, 1, 1);
      // R11 invalid clears flags
      apply("R11 idle", 0, 1, 1, 7, 5, 5, 0, 0, 0, 1, 1, 1, 1);
      for (int i = 0; i < 400; i++) begin
         apply("R6 random", ($urandom % 5) != 0, $urandom % 2, ($urandom % 4) != 0,
               $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4,
               $urandom % 4, $urandom % 4, $urandom % 2, $urandom % 2,
               ($urandom % 4) != 0, ($urandom % 4) != 0);
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule